// File: doc/BRIEF.md
# Triggered Event Gating Window

This block opens a gating window of programmable length when an external trigger rises. Only detector events that arrive while the window is open are passed on. Each accepted event is timestamped against the window's closing edge rather than its opening edge. Fine time is modelled synchronously, with one clock cycle standing for one fine-time tick. A down-counter stands in for both the delay-line window and the time-to-digital converter.

Four detector lines share one timestamp channel. Within a window, only the first event is forwarded, together with the index of the line that produced it. Every later event in that window is counted as dropped. The result waits in a single output slot, held under a valid/ready handshake, until the consumer takes it.

A trigger that rises while a window is already open does not restart the window. Instead it sets a sticky flag, so the host can tell that windows would have overlapped.

Top module: `gate_window`

## Requirements
- R1: A rising edge on `trig` while `enable` is high and no window is open opens a window lasting `win_len` ticks, with `win_len` sampled at that edge. A `win_len` of zero opens no window.
- R2: An event on `evt` that arrives while no window is open produces no output and leaves the drop count unchanged.
- R3: The timestamp of an accepted event is the number of ticks left in the window, counting the current tick. An event in the first tick after the trigger edge gets `win_len`, and an event in the last open tick gets 1.
- R4: Only the first event tick of a window is forwarded. Each later event tick in the same window adds one to `drop_cnt`, which saturates at its all-ones value.
- R5: When several lines fire in the same tick, the lowest index wins. `out_ch` carries that index as a binary number (line 0 is 0, line 3 is 3).
- R6: A rising `trig` while a window is open neither restarts nor reshapes that window, and it sets `overlap_flag`. The flag stays set until reset.
- R7: Changing `win_len` while a window is open does not change that window's length or timestamps.
- R8: `out_valid`, `out_ts` and `out_ch` hold steady while `out_valid` is high and `out_ready` is low. The slot empties on a clock edge where both are high.
- R9: A first event that arrives while the output slot is still full and not being taken is dropped and counted in `drop_cnt`. The held result is not changed.
- R10: While `enable` is low, rising triggers open no window, events are ignored, and any open window closes at the next edge.
- R11: Asserting `rst_n` low closes any open window, empties the output slot, and clears `overlap_flag` and `drop_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one fine-time tick |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows windows to open and stay open |
| trig | input | 1 | External trigger; its rising edge starts a window |
| evt | input | 4 | Detector event lines, sampled once per tick |
| win_len | input | 16 | Window length in ticks, sampled at the trigger edge |
| out_ready | input | 1 | Consumer accepts the held result |
| out_valid | output | 1 | A result is held in the output slot |
| out_ts | output | 22 | Ticks from the accepted event to the window end |
| out_ch | output | 2 | Index of the line that won the tick |
| overlap_flag | output | 1 | Sticky: a trigger rose while a window was open |
| drop_cnt | output | 8 | Saturating count of events dropped inside windows |

## Verification
The hardest state to reach from the ports is a first event that finds the output slot still occupied by the previous window's result. To get there, the stimulus stalls `out_ready`, lets a whole window run to its end, and opens a second window. It then fires an event into that second window and checks that the held timestamp is untouched and the drop count has moved. Saturation of the drop counter is reached the same way: one long window is flooded with back-to-back event ticks after its first event. The window edges are also probed: events in the last open tick and in the first closed tick, and a retrigger with a different length part-way through a window.

// File: rtl/gw_pkg.sv
package gw_pkg;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    localparam int GW_LINES = 4;

endpackage

// File: rtl/gw_trig_edge.sv
module gw_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rise
);
    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig;
        rise   = trig & ~trig_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end
endmodule

// File: rtl/gw_prio_pick.sv
module gw_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        // scan downward so the lowest set line is the last written
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/gw_window.sv
module gw_window
    import gw_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rise,
    input  logic [WIN_W-1:0] win_len,
    input  logic             taken,
    output logic             open,
    output logic [WIN_W-1:0] rem,
    output logic             got,
    output logic             overlap
);
    typedef struct packed {
        win_state_e       st;
        logic [WIN_W-1:0] rem;
        logic             got;
        logic             overlap;
    } win_s;

    win_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.st  = WIN_IDLE;
            s_d.rem = '0;
        end else if (s_q.st == WIN_OPEN) begin
            if (rise) s_d.overlap = 1'b1;
            s_d.rem = s_q.rem - 1'b1;
            if (s_q.rem == WIN_W'(1)) s_d.st = WIN_IDLE;
        end else if (rise && (win_len != '0)) begin
            s_d.st  = WIN_OPEN;
            s_d.rem = win_len;
            s_d.got = 1'b0;
        end
        if (taken) s_d.got = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st      <= WIN_IDLE;
            s_q.rem     <= '0;
            s_q.got     <= 1'b0;
            s_q.overlap <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open    = (s_q.st == WIN_OPEN);
    assign rem     = s_q.rem;
    assign got     = s_q.got;
    assign overlap = s_q.overlap;
endmodule

// File: rtl/gw_out_slot.sv
module gw_out_slot #(
    parameter int TS_W   = 22,
    parameter int IDX_W  = 2,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              got,
    input  logic [TS_W-1:0]   ts_in,
    input  logic [IDX_W-1:0]  ch_in,
    input  logic              out_ready,
    output logic              taken,
    output logic              out_valid,
    output logic [TS_W-1:0]   out_ts,
    output logic [IDX_W-1:0]  out_ch,
    output logic [DROP_W-1:0] drop_cnt
);
    typedef struct packed {
        logic              valid;
        logic [TS_W-1:0]   ts;
        logic [IDX_W-1:0]  ch;
        logic [DROP_W-1:0] drops;
    } slot_s;

    slot_s s_d, s_q;
    logic  cand, slot_free, load, drop;

    always_comb begin
        cand      = live & ~got;
        slot_free = ~s_q.valid | out_ready;
        load      = cand & slot_free;
        drop      = live & (got | ~slot_free);
        taken     = cand;

        s_d = s_q;
        if (load) begin
            s_d.valid = 1'b1;
            s_d.ts    = ts_in;
            s_d.ch    = ch_in;
        end else if (out_ready) begin
            s_d.valid = 1'b0;
        end
        if (drop && (s_q.drops != '1)) s_d.drops = s_q.drops + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.valid <= 1'b0;
            s_q.ts    <= '0;
            s_q.ch    <= '0;
            s_q.drops <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_ts    = s_q.ts;
    assign out_ch    = s_q.ch;
    assign drop_cnt  = s_q.drops;
endmodule

// File: rtl/gate_window.sv
module gate_window #(
    parameter int LINES  = gw_pkg::GW_LINES,
    parameter int WIN_W  = 16,
    parameter int TS_W   = 22,
    parameter int DROP_W = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              trig,
    input  logic [LINES-1:0]  evt,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [TS_W-1:0]   out_ts,
    output logic [IDX_W-1:0]  out_ch,
    output logic              overlap_flag,
    output logic [DROP_W-1:0] drop_cnt
);
    logic             rise;
    logic             hit;
    logic [IDX_W-1:0] win_idx;
    logic             win_open;
    logic [WIN_W-1:0] win_rem;
    logic             win_got;
    logic             taken;
    logic             live;
    logic [TS_W-1:0]  ts_now;

    gw_trig_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .rise  (rise)
    );

    gw_prio_pick #(.N(LINES), .IDX_W(IDX_W)) u_pick (
        .req (evt),
        .hit (hit),
        .idx (win_idx)
    );

    gw_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .rise    (rise),
        .win_len (win_len),
        .taken   (taken),
        .open    (win_open),
        .rem     (win_rem),
        .got     (win_got),
        .overlap (overlap_flag)
    );

    assign live   = win_open & enable & hit;
    assign ts_now = TS_W'(win_rem);

    gw_out_slot #(.TS_W(TS_W), .IDX_W(IDX_W), .DROP_W(DROP_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .got       (win_got),
        .ts_in     (ts_now),
        .ch_in     (win_idx),
        .out_ready (out_ready),
        .taken     (taken),
        .out_valid (out_valid),
        .out_ts    (out_ts),
        .out_ch    (out_ch),
        .drop_cnt  (drop_cnt)
    );
endmodule

// File: rtl/gw_checker.sv
module gw_checker #(
    parameter int WIN_W  = 16,
    parameter int TS_W   = 22,
    parameter int IDX_W  = 2,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              out_ready,
    input logic              out_valid,
    input logic [TS_W-1:0]   out_ts,
    input logic [IDX_W-1:0]  out_ch,
    input logic              overlap_flag,
    input logic [DROP_W-1:0] drop_cnt,
    input logic              win_open,
    input logic [WIN_W-1:0]  win_rem
);
    p_rem_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (win_rem != '0));

    p_new_result_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(win_open));

    p_ts_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ts != '0));

    p_drop_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (drop_cnt >= $past(drop_cnt)));

    p_overlap_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_flag |=> overlap_flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_ch)));

    p_enable_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !win_open);
endmodule

bind gate_window gw_checker #(
    .WIN_W(WIN_W), .TS_W(TS_W), .IDX_W(IDX_W), .DROP_W(DROP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_ts       (out_ts),
    .out_ch       (out_ch),
    .overlap_flag (overlap_flag),
    .drop_cnt     (drop_cnt),
    .win_open     (win_open),
    .win_rem      (win_rem)
);

// File: tb/tb_gate_window.sv
module tb_gate_window;
    localparam int LINES  = 4;
    localparam int WIN_W  = 16;
    localparam int TS_W   = 22;
    localparam int DROP_W = 8;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              enable;
    logic              trig;
    logic [LINES-1:0]  evt;
    logic [WIN_W-1:0]  win_len;
    logic              out_ready;
    logic              out_valid;
    logic [TS_W-1:0]   out_ts;
    logic [IDX_W-1:0]  out_ch;
    logic              overlap_flag;
    logic [DROP_W-1:0] drop_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_drop = 0;
    bit done = 1'b0;

    logic [IDX_W+TS_W-1:0] exp_q[$];
    string                 tag_q[$];

    always #10 clk = ~clk;

    gate_window #(.LINES(LINES), .WIN_W(WIN_W), .TS_W(TS_W), .DROP_W(DROP_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .trig         (trig),
        .evt          (evt),
        .win_len      (win_len),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_ts       (out_ts),
        .out_ch       (out_ch),
        .overlap_flag (overlap_flag),
        .drop_cnt     (drop_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_win(input int len);
        win_len = WIN_W'(len);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic fire(input logic [LINES-1:0] m, input bit expect_out,
                        input int ch, input int ts, input string tag);
        if (expect_out) begin
            exp_q.push_back({IDX_W'(ch), TS_W'(ts)});
            tag_q.push_back(tag);
        end
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic add_drop();
        if (exp_drop < 255) exp_drop++;
    endtask

    // monitor: a transfer is due at the next rising edge
    always @(negedge clk) begin
        #2;
        if (rst_n === 1'b1 && out_valid === 1'b1 && out_ready === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2 unexpected result actual=%0d expected=none", out_ts);
            end else begin
                logic [IDX_W+TS_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " ts"}, 32'(out_ts), 32'(e[TS_W-1:0]));
                chk({t, " ch"}, 32'(out_ch), 32'(e[IDX_W+TS_W-1:TS_W]));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; trig = 1'b0; evt = '0;
        win_len = '0; out_ready = 1'b1;
        gap(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset valid", 32'(out_valid), 0);
        chk("R11 reset overlap", 32'(overlap_flag), 0);
        chk("R11 reset drops", 32'(drop_cnt), 0);

        // R3: first tick gets the full length
        start_win(5);
        fire(4'b0100, 1, 2, 5, "R3 first tick");
        gap(8);

        // R5 priority, R4 later event dropped
        start_win(8);
        gap(3);
        fire(4'b1010, 1, 1, 5, "R5 lowest index");
        gap(1);
        fire(4'b0001, 0, 0, 0, "");
        add_drop();
        gap(6);
        chk("R4 later event dropped", 32'(drop_cnt), 32'(exp_drop));

        // R2: event with no window
        fire(4'b1111, 0, 0, 0, "");
        gap(2);
        chk("R2 closed no drop", 32'(drop_cnt), 32'(exp_drop));
        chk("R2 closed no output", 32'(out_valid), 0);

        // R3 last open tick, R2 first closed tick
        start_win(4);
        gap(3);
        fire(4'b0001, 1, 0, 1, "R3 last tick");
        gap(4);
        start_win(4);
        gap(4);
        fire(4'b0010, 0, 0, 0, "");
        gap(2);
        chk("R2 after close no drop", 32'(drop_cnt), 32'(exp_drop));
        chk("R2 after close no output", 32'(out_valid), 0);

        // R7: length change during window
        start_win(6);
        win_len = WIN_W'(2);
        gap(5);
        fire(4'b1000, 1, 3, 1, "R7 length held");
        gap(3);
        chk("R6 no spurious overlap", 32'(overlap_flag), 0);

        // R6: retrigger while open
        start_win(10);
        gap(2);
        start_win(3);
        chk("R6 overlap set", 32'(overlap_flag), 1);
        gap(1);
        fire(4'b0100, 1, 2, 6, "R6 window not restarted");
        gap(8);
        chk("R6 overlap sticky", 32'(overlap_flag), 1);

        // R8 hold, R9 slot full
        out_ready = 1'b0;
        start_win(5);
        gap(1);
        fire(4'b0010, 1, 1, 4, "R8 held result");
        for (int i = 0; i < 3; i++) begin
            chk("R8 valid held", 32'(out_valid), 1);
            chk("R8 ts held", 32'(out_ts), 4);
            @(negedge clk);
        end
        start_win(3);
        fire(4'b0001, 0, 0, 0, "");
        add_drop();
        gap(1);
        chk("R9 held ts unchanged", 32'(out_ts), 4);
        chk("R9 full slot drop", 32'(drop_cnt), 32'(exp_drop));
        out_ready = 1'b1;
        gap(3);
        chk("R8 slot emptied", 32'(out_valid), 0);

        // R10: enable low
        enable = 1'b0;
        start_win(5);
        fire(4'b0001, 0, 0, 0, "");
        gap(2);
        enable = 1'b1;
        chk("R10 disabled no output", 32'(out_valid), 0);
        start_win(6);
        gap(1);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        gap(1);
        fire(4'b0001, 0, 0, 0, "");
        gap(4);
        chk("R10 window closed", 32'(out_valid), 0);
        chk("R10 no drop", 32'(drop_cnt), 32'(exp_drop));

        // R1: zero length opens nothing
        start_win(0);
        fire(4'b0001, 0, 0, 0, "");
        gap(2);
        chk("R1 zero length", 32'(drop_cnt), 32'(exp_drop));
        chk("R1 zero length no output", 32'(out_valid), 0);

        // R4: saturation
        start_win(300);
        fire(4'b0100, 1, 2, 300, "R4 long window");
        for (int i = 0; i < 260; i++) begin
            fire(4'b1000, 0, 0, 0, "");
            add_drop();
        end
        gap(50);
        chk("R4 drop saturates", 32'(drop_cnt), 32'(exp_drop));

        // R11: reset mid window
        start_win(20);
        gap(2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_drop = 0;
        chk("R11 overlap cleared", 32'(overlap_flag), 0);
        chk("R11 drops cleared", 32'(drop_cnt), 0);
        fire(4'b0001, 0, 0, 0, "");
        gap(2);
        chk("R11 window closed", 32'(out_valid), 0);
        chk("R11 no drop after reset", 32'(drop_cnt), 0);

        chk("R2 all expected seen", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule